// File: doc/BRIEF.md
# SMBus Word-Access Host Sequencer

This block carries out one 16-bit word transfer with a power-management microcontroller. It does this by programming an SMBus host controller's byte-wide register file in a fixed order. A request port supplies three things: a direction flag, a command byte and, for writes, a data word. The sequencer first enables the host and clears its stale status. It then loads the slave address, which encodes the direction, followed by the command and, for writes, the two data bytes. Last, it writes the start code to the control register.

After the start code, the sequencer polls the host status register. It waits until the completion interrupt bit or an error bit shows up. When a read completes, the sequencer fetches both data registers and presents the word together with a one-cycle done pulse. An error bit, or silence that lasts longer than a programmable cycle limit, ends the transfer with a one-cycle fail pulse instead.

The register-file port uses a simple timing model. It carries one access per cycle. A write takes effect at the clock edge. Read data is registered and returns one cycle after the read strobe.

Top module: `smb_word_seq`

## Requirements
- R1: After synchronous reset, req_ready is 1, done and fail are 0, hr_we and hr_re are 0, and rd_word is 0.
- R2: A request is taken only while req_ready is 1. req_ready stays 0 from acceptance until the transfer ends. A req_valid held during that time leaves the register writes of the running transfer unchanged and starts nothing.
- R3: Every transfer opens with two writes on consecutive cycles. The first writes 01h to the configuration register (index 0). The second writes 1Eh to the status register (index 1). Because the status register clears on write-one (bits 1 to 4), a completion bit left over from an earlier transfer cannot end the new one.
- R4: The next write goes to the slave-address register (index 3). It carries 04h for a write transfer and 05h for a read transfer. The command byte then follows in the command register (index 4).
- R5: A write transfer next loads the high data byte into data register 0 (index 5) and the low byte into data register 1 (index 6). A read transfer skips both. In either case the last write is 4Ch to the control register (index 2), which carries the start bit 6.
- R6: After the start write, the status register is polled by reads. A write transfer ends with done once status bit 1 (completion) is seen. The bus never carries a write and a read in the same cycle.
- R7: On completion of a read transfer, data registers 0 and 1 are read. rd_word becomes {data0, data1}, presented with the done pulse.
- R8: A status value with any of bits 2, 3 or 4 set ends the transfer with fail and not done, even if bit 1 is also set. No data register is read, and rd_word keeps its previous value.
- R9: If neither completion nor an error appears, fail is raised. It comes no earlier than tmo_limit cycles and no later than tmo_limit+8 cycles after the start write.
- R10: done and fail are single-cycle pulses and are never high together. req_ready is 1 in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_read | input | 1 | 1 = read word from the device, 0 = write word |
| req_cmd | input | 8 | Command byte |
| req_wword | input | 16 | Word to write (high byte first on the bus) |
| tmo_limit | input | TW | Completion wait limit in cycles |
| hr_addr | output | 3 | Host register index |
| hr_wdata | output | 8 | Host register write data |
| hr_we | output | 1 | Host register write strobe |
| hr_re | output | 1 | Host register read strobe |
| hr_rdata | input | 8 | Host register read data, valid one cycle after hr_re |
| rd_word | output | 16 | Word returned by the last successful read |
| done | output | 1 | Transfer completed pulse |
| fail | output | 1 | Transfer failed pulse (device error or timeout) |

## Verification
Two situations are hard to reach from the ports. The first is a completion bit left over in the status register before a new transfer. The bench's register-file model injects that stale bit on purpose, then gives the device a long reply latency. A sequencer that skipped the clear would finish well before the device answers. The second is an error that arrives together with the completion bit. The model raises both in the same status value. The bench then checks that fail wins, that no data register is read and that the returned word is left untouched. The timeout path is reached by having the model never answer, and the fail pulse is timed against the start write.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned STEP_W = 3;

  localparam logic [REG_AW-1:0] R_CFG  = 3'd0;
  localparam logic [REG_AW-1:0] R_STS  = 3'd1;
  localparam logic [REG_AW-1:0] R_CTL  = 3'd2;
  localparam logic [REG_AW-1:0] R_ADDR = 3'd3;
  localparam logic [REG_AW-1:0] R_CMD  = 3'd4;
  localparam logic [REG_AW-1:0] R_DAT0 = 3'd5;
  localparam logic [REG_AW-1:0] R_DAT1 = 3'd6;

  localparam logic [BYTE_W-1:0] CFG_ENABLE   = 8'h01;
  localparam logic [BYTE_W-1:0] STS_CLEAR    = 8'h1E;
  localparam logic [BYTE_W-1:0] SLV_WRITE    = 8'h04;
  localparam logic [BYTE_W-1:0] SLV_READ     = 8'h05;
  localparam logic [BYTE_W-1:0] CTL_GO_WORD  = 8'h4C;
  localparam logic [BYTE_W-1:0] STS_ERR_MASK = 8'h1C;
  localparam int unsigned       STS_INTR_BIT = 1;

  localparam logic [STEP_W-1:0] STEP_CMD  = 3'd3;
  localparam logic [STEP_W-1:0] STEP_LAST = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_RD_ISSUE, S_RD_WAIT, S_RD_USE} seq_st_t;
  typedef enum logic [1:0] {T_STS, T_DAT0, T_DAT1} rd_tgt_t;
endpackage

// File: rtl/smbseq_step_rom.sv
module smbseq_step_rom
  import smbseq_pkg::*;
(
  input  logic [STEP_W-1:0]   step,
  input  logic                is_read,
  input  logic [BYTE_W-1:0]   cmd,
  input  logic [2*BYTE_W-1:0] wword,
  output logic [REG_AW-1:0]   addr,
  output logic [BYTE_W-1:0]   data,
  output logic [STEP_W-1:0]   next_step,
  output logic                last
);
  always_comb begin
    case (step)
      3'd0:    begin addr = R_CFG;  data = CFG_ENABLE; end
      3'd1:    begin addr = R_STS;  data = STS_CLEAR; end
      3'd2:    begin addr = R_ADDR; data = is_read ? SLV_READ : SLV_WRITE; end
      3'd3:    begin addr = R_CMD;  data = cmd; end
      3'd4:    begin addr = R_DAT0; data = wword[2*BYTE_W-1:BYTE_W]; end
      3'd5:    begin addr = R_DAT1; data = wword[BYTE_W-1:0]; end
      default: begin addr = R_CTL;  data = CTL_GO_WORD; end
    endcase
  end

  assign last      = (step >= STEP_LAST);
  assign next_step = (is_read && step == STEP_CMD) ? STEP_LAST : step + 1'b1;
endmodule

// File: rtl/smbseq_timer.sv
module smbseq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/smb_word_seq.sv
module smb_word_seq
  import smbseq_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_read,
  input  logic [BYTE_W-1:0]   req_cmd,
  input  logic [2*BYTE_W-1:0] req_wword,
  input  logic [TW-1:0]       tmo_limit,
  output logic [REG_AW-1:0]   hr_addr,
  output logic [BYTE_W-1:0]   hr_wdata,
  output logic                hr_we,
  output logic                hr_re,
  input  logic [BYTE_W-1:0]   hr_rdata,
  output logic [2*BYTE_W-1:0] rd_word,
  output logic                done,
  output logic                fail
);
  seq_st_t             st;
  rd_tgt_t             tgt;
  logic [STEP_W-1:0]   step;
  logic                is_rd;
  logic [BYTE_W-1:0]   cmd_q;
  logic [2*BYTE_W-1:0] wword_q;
  logic [BYTE_W-1:0]   hi_q;

  logic [REG_AW-1:0]   rom_addr;
  logic [BYTE_W-1:0]   rom_data;
  logic [STEP_W-1:0]   rom_next;
  logic                rom_last;
  logic                tmo_clr, tmo_en, tmo_hit;
  logic                sts_err, sts_intr;
  logic [REG_AW-1:0]   rd_addr;

  smbseq_step_rom u_rom (
    .step(step), .is_read(is_rd), .cmd(cmd_q), .wword(wword_q),
    .addr(rom_addr), .data(rom_data), .next_step(rom_next), .last(rom_last)
  );

  assign tmo_clr = (st == S_PROG) && rom_last;
  assign tmo_en  = (st != S_IDLE) && (st != S_PROG) && (tgt == T_STS);

  smbseq_timer #(.TW(TW)) u_tmo (
    .clk(clk), .rst(rst), .clr(tmo_clr), .en(tmo_en),
    .limit(tmo_limit), .expired(tmo_hit)
  );

  assign req_ready = (st == S_IDLE);
  assign sts_err   = |(hr_rdata & STS_ERR_MASK);
  assign sts_intr  = hr_rdata[STS_INTR_BIT];

  always_comb begin
    case (tgt)
      T_DAT0:  rd_addr = R_DAT0;
      T_DAT1:  rd_addr = R_DAT1;
      default: rd_addr = R_STS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      tgt      <= T_STS;
      step     <= '0;
      is_rd    <= 1'b0;
      cmd_q    <= '0;
      wword_q  <= '0;
      hi_q     <= '0;
      hr_addr  <= '0;
      hr_wdata <= '0;
      hr_we    <= 1'b0;
      hr_re    <= 1'b0;
      rd_word  <= '0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      hr_we <= 1'b0;
      hr_re <= 1'b0;
      done  <= 1'b0;
      fail  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            is_rd   <= req_read;
            cmd_q   <= req_cmd;
            wword_q <= req_wword;
            step    <= '0;
            st      <= S_PROG;
          end
        end
        S_PROG: begin
          hr_we    <= 1'b1;
          hr_addr  <= rom_addr;
          hr_wdata <= rom_data;
          if (rom_last) begin
            tgt <= T_STS;
            st  <= S_RD_ISSUE;
          end else begin
            step <= rom_next;
          end
        end
        S_RD_ISSUE: begin
          hr_re   <= 1'b1;
          hr_addr <= rd_addr;
          st      <= S_RD_WAIT;
        end
        S_RD_WAIT: st <= S_RD_USE;
        S_RD_USE: begin
          case (tgt)
            T_STS: begin
              if (sts_err) begin
                fail <= 1'b1;
                st   <= S_IDLE;
              end else if (sts_intr) begin
                if (is_rd) begin
                  tgt <= T_DAT0;
                  st  <= S_RD_ISSUE;
                end else begin
                  done <= 1'b1;
                  st   <= S_IDLE;
                end
              end else if (tmo_hit) begin
                fail <= 1'b1;
                st   <= S_IDLE;
              end else begin
                st <= S_RD_ISSUE;
              end
            end
            T_DAT0: begin
              hi_q <= hr_rdata;
              tgt  <= T_DAT1;
              st   <= S_RD_ISSUE;
            end
            default: begin
              rd_word <= {hi_q, hr_rdata};
              done    <= 1'b1;
              tgt     <= T_STS;
              st      <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_word_seq_chk.sv
module smb_word_seq_chk
  import smbseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [REG_AW-1:0] hr_addr,
  input logic [BYTE_W-1:0] hr_wdata,
  input logic              hr_we,
  input logic              hr_re,
  input logic              done,
  input logic              fail
);
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hr_we && hr_re)); // R6

  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && fail)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail); // R10

  AST_READY_AT_END: assert property (@(posedge clk) disable iff (rst)
    (done || fail) |-> req_ready); // R10

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(hr_we || hr_re)); // R2

  AST_CFG_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> ##2 (hr_we && hr_addr == R_CFG && hr_wdata == CFG_ENABLE)); // R3

  AST_CLEAR_AFTER_CFG: assert property (@(posedge clk) disable iff (rst)
    (hr_we && hr_addr == R_CFG) |=> (hr_we && hr_addr == R_STS && hr_wdata == STS_CLEAR)); // R3
endmodule

bind smb_word_seq smb_word_seq_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .hr_addr(hr_addr), .hr_wdata(hr_wdata), .hr_we(hr_we), .hr_re(hr_re),
  .done(done), .fail(fail)
);

// File: tb/tb_smb_word_seq.sv
module tb_smb_word_seq;
  import smbseq_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        req_valid, req_ready, req_read;
  logic [7:0]  req_cmd;
  logic [15:0] req_wword;
  logic [15:0] tmo_limit;
  logic [2:0]  hr_addr;
  logic [7:0]  hr_wdata, hr_rdata;
  logic        hr_we, hr_re;
  logic [15:0] rd_word;
  logic        done, fail;

  smb_word_seq #(.TW(16)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_cmd(req_cmd), .req_wword(req_wword),
    .tmo_limit(tmo_limit), .hr_addr(hr_addr), .hr_wdata(hr_wdata),
    .hr_we(hr_we), .hr_re(hr_re), .hr_rdata(hr_rdata),
    .rd_word(rd_word), .done(done), .fail(fail)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // register-file and device model
  logic [7:0]  rf [8];
  logic [10:0] wlog [256];
  int          nlog = 0;
  int          ndat_rd = 0;
  int          cd = 0;
  logic        armed = 1'b0;
  int          ctl_cyc = 0;
  logic [7:0]  resp_status = 8'h02;
  logic [7:0]  resp_hi = 8'h00;
  logic [7:0]  resp_lo = 8'h00;
  int          resp_lat = 5;
  logic        poke = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
      armed    <= 1'b0;
      hr_rdata <= 8'h00;
    end else begin
      if (poke) rf[R_STS] <= 8'h02;
      if (hr_re) begin
        hr_rdata <= rf[hr_addr];
        if (hr_addr == R_DAT0 || hr_addr == R_DAT1) ndat_rd <= ndat_rd + 1;
      end
      if (hr_we) begin
        wlog[nlog[7:0]] <= {hr_addr, hr_wdata};
        nlog <= nlog + 1;
        if (hr_addr == R_STS) rf[R_STS] <= rf[R_STS] & ~hr_wdata;
        else rf[hr_addr] <= hr_wdata;
        if (hr_addr == R_CTL && hr_wdata[6]) begin
          armed   <= 1'b1;
          cd      <= resp_lat;
          ctl_cyc <= cyc;
        end
      end else if (armed) begin
        if (cd == 0) begin
          armed <= 1'b0;
          if (resp_status != 8'h00) begin
            rf[R_STS]  <= rf[R_STS] | resp_status;
            rf[R_DAT0] <= resp_hi;
            rf[R_DAT1] <= resp_lo;
          end
        end else begin
          cd <= cd - 1;
        end
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input int idx, input logic [2:0] a, input logic [7:0] d, input string tag);
    chk(wlog[idx[7:0]] == {a, d}, tag, {21'd0, wlog[idx[7:0]]}, {21'd0, a, d});
  endtask

  task automatic start(input logic rd, input logic [7:0] c, input logic [15:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_cmd = c; req_wword = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_end(output logic gd, output logic gf, output int el);
    gd = 1'b0; gf = 1'b0;
    for (int i = 0; i < 3000 && !gd && !gf; i++) begin
      @(negedge clk);
      gd = done; gf = fail;
    end
    el = cyc - ctl_cyc;
    if (gd || gf) begin
      chk(!(done && fail), "R10 done/fail together", {30'd0, done, fail}, 32'h1);
      @(negedge clk);
      chk(!done && !fail, "R10 pulse width", {30'd0, done, fail}, 32'h0);
      chk(req_ready, "R10 ready after end", {31'd0, req_ready}, 32'h1);
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'h1);
    chk(!done && !fail, "R1 done/fail", {30'd0, done, fail}, 32'h0);
    chk(!hr_we && !hr_re, "R1 bus strobes", {30'd0, hr_we, hr_re}, 32'h0);
    chk(rd_word == 16'h0, "R1 rd_word", {16'd0, rd_word}, 32'h0);
  endtask

  task automatic t_write_word;
    logic gd, gf; int el; int b;
    resp_status = 8'h02; resp_lat = 20;
    @(negedge clk); poke = 1'b1;
    @(negedge clk); poke = 1'b0;
    b = nlog;
    start(1'b0, 8'h3A, 16'hBEEF);
    wait_end(gd, gf, el);
    chk(gd && !gf, "R6 write completes on INTR", {30'd0, gd, gf}, 32'h2);
    chk(nlog - b == 7, "R5 write count", nlog - b, 32'd7);
    chk_log(b + 0, R_CFG, 8'h01, "R3 cfg enable");
    chk_log(b + 1, R_STS, 8'h1E, "R3 status clear");
    chk_log(b + 2, R_ADDR, 8'h04, "R4 write slave addr");
    chk_log(b + 3, R_CMD, 8'h3A, "R4 command");
    chk_log(b + 4, R_DAT0, 8'hBE, "R5 high byte");
    chk_log(b + 5, R_DAT1, 8'hEF, "R5 low byte");
    chk_log(b + 6, R_CTL, 8'h4C, "R5 start code");
    chk(el >= 20, "R3 stale INTR ignored", el, 32'd20);
  endtask

  task automatic t_read_word(input logic [7:0] hi, input logic [7:0] lo, input int lat, input logic [7:0] c);
    logic gd, gf; int el; int b; int db;
    resp_status = 8'h02; resp_lat = lat; resp_hi = hi; resp_lo = lo;
    b = nlog; db = ndat_rd;
    start(1'b1, c, 16'h0000);
    wait_end(gd, gf, el);
    chk(gd && !gf, "R7 read completes", {30'd0, gd, gf}, 32'h2);
    chk(rd_word == {hi, lo}, "R7 rd_word", {16'd0, rd_word}, {16'd0, hi, lo});
    chk(ndat_rd - db == 2, "R7 data reads", ndat_rd - db, 32'd2);
    chk(nlog - b == 5, "R5 read skips data writes", nlog - b, 32'd5);
    chk_log(b + 0, R_CFG, 8'h01, "R3 cfg enable (read)");
    chk_log(b + 1, R_STS, 8'h1E, "R3 status clear (read)");
    chk_log(b + 2, R_ADDR, 8'h05, "R4 read slave addr");
    chk_log(b + 3, R_CMD, c, "R4 command (read)");
    chk_log(b + 4, R_CTL, 8'h4C, "R5 start code (read)");
  endtask

  task automatic t_dev_error_read;
    logic gd, gf; int el; int db; logic [15:0] prev;
    prev = rd_word;
    resp_status = 8'h04; resp_lat = 5; resp_hi = 8'hAA; resp_lo = 8'h55;
    db = ndat_rd;
    start(1'b1, 8'h22, 16'h0000);
    wait_end(gd, gf, el);
    chk(gf && !gd, "R8 error read fails", {30'd0, gd, gf}, 32'h1);
    chk(rd_word == prev, "R8 rd_word kept", {16'd0, rd_word}, {16'd0, prev});
    chk(ndat_rd == db, "R8 no data reads", ndat_rd - db, 32'd0);
  endtask

  task automatic t_intr_and_error;
    logic gd, gf; int el;
    resp_status = 8'h12; resp_lat = 4;
    start(1'b0, 8'h44, 16'h0102);
    wait_end(gd, gf, el);
    chk(gf && !gd, "R8 error wins over INTR", {30'd0, gd, gf}, 32'h1);
  endtask

  task automatic t_timeout;
    logic gd, gf; int el;
    resp_status = 8'h00; resp_lat = 2; tmo_limit = 16'd40;
    start(1'b0, 8'h66, 16'h7788);
    wait_end(gd, gf, el);
    chk(gf && !gd, "R9 timeout fails", {30'd0, gd, gf}, 32'h1);
    chk(el >= 40 && el <= 48, "R9 timeout window", el, 32'd40);
    tmo_limit = 16'd1000;
  endtask

  task automatic t_busy_ignore;
    logic gd, gf; int el; int b; logic rdy_seen;
    resp_status = 8'h02; resp_lat = 10;
    b = nlog; rdy_seen = 1'b0;
    start(1'b0, 8'h55, 16'h1234);
    req_valid = 1'b1; req_read = 1'b1; req_cmd = 8'hEE; req_wword = 16'hFFFF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (req_ready) rdy_seen = 1'b1;
    end
    req_valid = 1'b0;
    chk(!rdy_seen, "R2 ready low while busy", {31'd0, rdy_seen}, 32'h0);
    wait_end(gd, gf, el);
    chk(gd, "R2 running transfer completes", {31'd0, gd}, 32'h1);
    chk(nlog - b == 7, "R2 single transfer", nlog - b, 32'd7);
    chk_log(b + 2, R_ADDR, 8'h04, "R2 direction unchanged");
    chk_log(b + 3, R_CMD, 8'h55, "R2 command unchanged");
    repeat (5) @(negedge clk);
    chk(nlog - b == 7, "R2 nothing started after", nlog - b, 32'd7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_read = 1'b0; req_cmd = 8'h00;
    req_wword = 16'h0000; tmo_limit = 16'd1000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_word();
    t_read_word(8'hC3, 8'h5A, 12, 8'h11);
    t_read_word(8'h0F, 8'hF0, 3, 8'h7E);
    t_dev_error_read();
    t_intr_and_error();
    t_timeout();
    t_busy_ignore();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule